// File: doc/BRIEF.md
# Shifted-Operand Barrel Shifter

This block forms the second ALU operand of an integer datapath. It takes a 32-bit source word and shifts or rotates it. The shift amount comes from one of two places: a small immediate field or a general-purpose register. The block also returns the carry-out that the shift produces, which the flag logic outside the block may take or ignore.

The block is purely combinational. The immediate amount follows encoding rules in which the legal range depends on the shift kind. When an immediate amount falls outside its range, the block raises an illegal-encoding flag and passes the source through, so the decoder can trap. A register amount is always legal. Only its low byte counts, and amounts at or beyond the word width saturate in the usual architectural way. A rotate-with-extend mode shifts right by one through the carry flag. When shifting is disabled, the source and carry pass through untouched.

Top module: `operand_shifter`

## Requirements
- R1: `kind_i` selects the shift kind: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. When `shift_en_i` is 0, `value_o` equals `src_i`, `carry_o` equals `carry_i` and `bad_enc_o` is 0, whatever the other inputs are.
- R2: An immediate logical-left amount is legal from 1 to 31. An amount of 0, or of 32 and above, raises `bad_enc_o`.
- R3: An immediate rotate-right amount is legal from 1 to 31. An amount of 0, or of 32 and above, raises `bad_enc_o`.
- R4: An immediate logical-right or arithmetic-right amount is legal from 1 to 32. An amount of 0, or of 33 and above, raises `bad_enc_o`.
- R5: While `bad_enc_o` is 1, `value_o` equals `src_i` and `carry_o` equals `carry_i`.
- R6: Logical shifts by n from 1 to 31 fill the vacated bits with zeros, and `carry_o` is the last bit shifted out. For n = 32 the value is 0 and the carry is the bit at the outgoing edge: bit 0 for a left shift, bit 31 for a right shift. For n above 32, both the value and the carry are 0.
- R7: An arithmetic right shift fills the vacated bits with `src_i[31]` (0xDEADBEEF by 16 gives 0xFFFFDEAD). For n of 32 or more, every result bit and the carry equal the sign bit.
- R8: Rotate right by n uses n modulo 32, and `carry_o` is bit 31 of the result. A nonzero register amount that is a multiple of 32 leaves the value unchanged and gives `src_i[31]` as the carry.
- R9: When `amt_sel_reg_i` is 1, the amount is `amt_reg_i[7:0]` and the upper 24 bits are ignored: 0xBADBAD01 shifts by 1. A register amount never raises `bad_enc_o`. A register amount of 0 passes both the value and `carry_i` through.
- R10: When `rrx_i` is 1 with shifting enabled, the kind and the amount are ignored. The result is `{carry_i, src_i[31:1]}` and `carry_o` is `src_i[0]`: 0xDEADBEEF gives 0x6F56DF77 with carry 0 and 0xEF56DF77 with carry 1. This mode is never illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Source word to be shifted |
| kind_i | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| rrx_i | input | 1 | Rotate right by one through carry |
| amt_sel_reg_i | input | 1 | 1: amount from register, 0: from immediate |
| imm_amt_i | input | 6 | Immediate shift amount, 0 to 63 |
| amt_reg_i | input | 32 | Register holding the shift amount |
| carry_i | input | 1 | Current carry flag |
| shift_en_i | input | 1 | 0: pass the source and carry through |
| value_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |
| bad_enc_o | output | 1 | Immediate amount outside its legal range |

## Verification
Every output is a combinational function of the inputs present at the same moment, so each result is due in the cycle its stimulus is applied, with no register on the path. The bench changes the inputs on a rising clock edge and compares all three outputs on the following falling edge. This leaves half a period for the logic to settle, and no result depends on the order in which processes run at an edge. The sweep covers every kind with every immediate amount from 0 to 63 and every low-byte register amount under junk upper bits, across several source patterns.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

endpackage

// File: rtl/shamt_decode.sv
module shamt_decode
  import shifter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 6,
  parameter int AMT_REG_W = 32,
  parameter int AMT_USE_W = 8,
  localparam int AMT_W    = (AMT_USE_W > IMM_AMT_W) ? AMT_USE_W : IMM_AMT_W
) (
  input  shift_kind_e          kind,
  input  logic                 use_reg,
  input  logic [IMM_AMT_W-1:0] imm_amt,
  input  logic [AMT_REG_W-1:0] amt_reg,
  output logic [AMT_W-1:0]     eff_amt,
  output logic                 imm_bad
);

  // Legal immediate range depends on the kind; right shifts may reach the width.
  function automatic logic imm_in_range(shift_kind_e k, logic [IMM_AMT_W-1:0] a);
    int n;
    n = int'(a);
    case (k)
      SK_LSR, SK_ASR: return (n >= 1) && (n <= DATA_W);
      default:        return (n >= 1) && (n <  DATA_W);
    endcase
  endfunction

  logic [AMT_USE_W-1:0] reg_low;
  assign reg_low = amt_reg[AMT_USE_W-1:0];

  assign eff_amt = use_reg ? AMT_W'(reg_low) : AMT_W'(imm_amt);
  assign imm_bad = !use_reg && !imm_in_range(kind, imm_amt);

  always_comb begin
    if (!$isunknown({use_reg, imm_bad}))
      AST_REG_NEVER_BAD: assert (!(use_reg && imm_bad)); // R9
  end

  always_comb begin
    if (!$isunknown({use_reg, imm_amt, imm_bad}))
      AST_IMM_ZERO_BAD: assert (use_reg || (imm_amt != '0) || imm_bad); // R2
  end

endmodule

// File: rtl/shift_core.sv
module shift_core
  import shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  shift_kind_e       kind,
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  // Each function returns {carry, value}.
  function automatic logic [DATA_W:0] f_lsl(logic [DATA_W-1:0] s, logic [AMT_W-1:0] a, logic c);
    int n;
    logic [ROT_W-1:0] idx;
    n = int'(a);
    idx = ROT_W'(DATA_W - n);
    if (n == 0)           return {c, s};
    else if (n < DATA_W)  return {s[idx], s << n};
    else if (n == DATA_W) return {s[0], {DATA_W{1'b0}}};
    else                  return '0;
  endfunction

  function automatic logic [DATA_W:0] f_lsr(logic [DATA_W-1:0] s, logic [AMT_W-1:0] a, logic c);
    int n;
    logic [ROT_W-1:0] idx;
    n = int'(a);
    idx = ROT_W'(n - 1);
    if (n == 0)           return {c, s};
    else if (n < DATA_W)  return {s[idx], s >> n};
    else if (n == DATA_W) return {s[DATA_W-1], {DATA_W{1'b0}}};
    else                  return '0;
  endfunction

  function automatic logic [DATA_W:0] f_asr(logic [DATA_W-1:0] s, logic [AMT_W-1:0] a, logic c);
    int n;
    logic [ROT_W-1:0] idx;
    logic [DATA_W-1:0] t;
    n = int'(a);
    idx = ROT_W'(n - 1);
    t = $unsigned($signed(s) >>> n);
    if (n == 0)          return {c, s};
    else if (n < DATA_W) return {s[idx], t};
    else                 return {s[DATA_W-1], {DATA_W{s[DATA_W-1]}}};
  endfunction

  function automatic logic [DATA_W:0] f_ror(logic [DATA_W-1:0] s, logic [AMT_W-1:0] a, logic c);
    logic [ROT_W-1:0] r;
    logic [DATA_W-1:0] t;
    r = a[ROT_W-1:0];
    t = (s >> r) | (s << (DATA_W - int'(r)));
    if (a == '0)      return {c, s};
    else if (r == '0) return {s[DATA_W-1], s};
    else              return {t[DATA_W-1], t};
  endfunction

  logic [DATA_W:0] pick;

  always_comb begin
    case (kind)
      SK_LSL:  pick = f_lsl(src, amt, cin);
      SK_LSR:  pick = f_lsr(src, amt, cin);
      SK_ASR:  pick = f_asr(src, amt, cin);
      default: pick = f_ror(src, amt, cin);
    endcase
  end

  assign res  = pick[DATA_W-1:0];
  assign cout = pick[DATA_W];

  always_comb begin
    if (!$isunknown({kind, src, amt, res}))
      AST_ASR_SIGN_KEPT: assert (!(kind == SK_ASR) || (res[DATA_W-1] == src[DATA_W-1])); // R7
  end

  always_comb begin
    if (!$isunknown({kind, amt, res}))
      AST_LSL_LOW_ZERO: assert (!(kind == SK_LSL && amt != '0) || !res[0]); // R6
  end

  always_comb begin
    if (!$isunknown({kind, amt, res, cout}))
      AST_ROR_CARRY_TOP: assert (!(kind == SK_ROR && amt != '0) || (cout == res[DATA_W-1])); // R8
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shifter_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_AMT_W = 6,
  parameter int AMT_REG_W = 32,
  parameter int AMT_USE_W = 8
) (
  input  logic [DATA_W-1:0]    src_i,
  input  logic [1:0]           kind_i,
  input  logic                 rrx_i,
  input  logic                 amt_sel_reg_i,
  input  logic [IMM_AMT_W-1:0] imm_amt_i,
  input  logic [AMT_REG_W-1:0] amt_reg_i,
  input  logic                 carry_i,
  input  logic                 shift_en_i,
  output logic [DATA_W-1:0]    value_o,
  output logic                 carry_o,
  output logic                 bad_enc_o
);

  localparam int AMT_W = (AMT_USE_W > IMM_AMT_W) ? AMT_USE_W : IMM_AMT_W;

  shift_kind_e       kind;
  logic [AMT_W-1:0]  eff_amt;
  logic              imm_bad;
  logic [DATA_W-1:0] core_val;
  logic              core_cy;
  logic [DATA_W-1:0] rrx_val;
  logic              ext_active;
  logic              shift_active;

  assign kind = shift_kind_e'(kind_i);

  shamt_decode #(
    .DATA_W   (DATA_W),
    .IMM_AMT_W(IMM_AMT_W),
    .AMT_REG_W(AMT_REG_W),
    .AMT_USE_W(AMT_USE_W)
  ) u_decode (
    .kind   (kind),
    .use_reg(amt_sel_reg_i),
    .imm_amt(imm_amt_i),
    .amt_reg(amt_reg_i),
    .eff_amt(eff_amt),
    .imm_bad(imm_bad)
  );

  shift_core #(
    .DATA_W(DATA_W),
    .AMT_W (AMT_W)
  ) u_core (
    .kind(kind),
    .src (src_i),
    .amt (eff_amt),
    .cin (carry_i),
    .res (core_val),
    .cout(core_cy)
  );

  // Rotate-through-carry path, one position.
  assign rrx_val      = {carry_i, src_i[DATA_W-1:1]};
  assign ext_active   = shift_en_i && rrx_i;
  assign shift_active = shift_en_i && !rrx_i && !imm_bad;
  assign bad_enc_o    = shift_en_i && !rrx_i && imm_bad;

  always_comb begin
    if (ext_active) begin
      value_o = rrx_val;
      carry_o = src_i[0];
    end else if (shift_active) begin
      value_o = core_val;
      carry_o = core_cy;
    end else begin
      value_o = src_i;
      carry_o = carry_i;
    end
  end

  always_comb begin
    if (!$isunknown({bad_enc_o, value_o, carry_o, src_i, carry_i}))
      AST_BAD_PASSES: assert (!bad_enc_o || (value_o == src_i && carry_o == carry_i)); // R5
  end

  always_comb begin
    if (!$isunknown({shift_en_i, bad_enc_o, value_o, carry_o, src_i, carry_i}))
      AST_DISABLED_PASS: assert (shift_en_i || (!bad_enc_o && value_o == src_i && carry_o == carry_i)); // R1
  end

  always_comb begin
    if (!$isunknown({ext_active, bad_enc_o, value_o, carry_o, src_i, carry_i}))
      AST_RRX_SHAPE: assert (!ext_active ||
        (!bad_enc_o && value_o[DATA_W-1] == carry_i && carry_o == src_i[0])); // R10
  end

  always_comb begin
    if (!$isunknown({shift_en_i, rrx_i, amt_sel_reg_i, amt_reg_i, value_o, carry_o, src_i, carry_i}))
      AST_REG_ZERO_HOLD: assert (!(shift_en_i && !rrx_i && amt_sel_reg_i && amt_reg_i[AMT_USE_W-1:0] == '0) ||
        (value_o == src_i && carry_o == carry_i)); // R9
  end

endmodule

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;

  logic        clk = 1'b0;
  logic [31:0] src_i = '0;
  logic [1:0]  kind_i = '0;
  logic        rrx_i = 1'b0;
  logic        amt_sel_reg_i = 1'b0;
  logic [5:0]  imm_amt_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic        shift_en_i = 1'b0;
  logic [31:0] value_o;
  logic        carry_o;
  logic        bad_enc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  operand_shifter u_dut (
    .src_i(src_i), .kind_i(kind_i), .rrx_i(rrx_i), .amt_sel_reg_i(amt_sel_reg_i),
    .imm_amt_i(imm_amt_i), .amt_reg_i(amt_reg_i), .carry_i(carry_i),
    .shift_en_i(shift_en_i), .value_o(value_o), .carry_o(carry_o), .bad_enc_o(bad_enc_o)
  );

  // Reference model: returns {bad, carry, value}, built on 65-bit windows.
  function automatic logic [33:0] model(logic [31:0] s, logic [1:0] k, logic x, logic rs,
                                        logic [5:0] imm, logic [31:0] ar, logic c, logic en);
    int n;
    logic [64:0] w;
    logic [63:0] dbl;
    logic [31:0] v;
    bit ok;
    if (!en) return {1'b0, c, s};
    if (x)   return {1'b0, s[0], c, s[31:1]};
    if (rs) n = int'(ar[7:0]);
    else begin
      n = int'(imm);
      if (k == 2'd1 || k == 2'd2) ok = (n >= 1 && n <= 32);
      else                        ok = (n >= 1 && n <= 31);
      if (!ok) return {1'b1, c, s};
    end
    if (n == 0) return {1'b0, c, s};
    if (n > 40 && k != 2'd3) n = 40;
    case (k)
      2'd0: begin w = {33'd0, s} << n;               return {1'b0, w[32], w[31:0]}; end
      2'd1: begin w = {s, 33'd0} >> n;               return {1'b0, w[32], w[64:33]}; end
      2'd2: begin w = $unsigned($signed({s, 33'd0}) >>> n); return {1'b0, w[32], w[64:33]}; end
      default: begin
        dbl = {s, s} >> (n % 32);
        v = dbl[31:0];
        return {1'b0, v[31], v};
      end
    endcase
  endfunction

  task automatic apply_check(string req, logic [31:0] s, logic [1:0] k, logic x, logic rs,
                             logic [5:0] imm, logic [31:0] ar, logic c, logic en);
    logic [33:0] exp;
    @(posedge clk);
    src_i = s; kind_i = k; rrx_i = x; amt_sel_reg_i = rs;
    imm_amt_i = imm; amt_reg_i = ar; carry_i = c; shift_en_i = en;
    exp = model(s, k, x, rs, imm, ar, c, en);
    @(negedge clk);
    checks++;
    if ({bad_enc_o, carry_o, value_o} !== exp) begin
      errors++;
      $display("FAIL %s src=%h kind=%0d rrx=%0b reg=%0b imm=%0d areg=%h cin=%0b: got bad=%0b c=%0b v=%h exp bad=%0b c=%0b v=%h",
               req, s, k, x, rs, imm, ar, c, bad_enc_o, carry_o, value_o, exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic direct(string req, logic [31:0] got, logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, want);
    end
  endtask

  logic [31:0] pats [6] = '{32'hDEADBEEF, 32'h80000001, 32'h7FFFFFFE, 32'h00000000, 32'hFFFFFFFF, 32'h12345678};

  initial begin
    // R1 reset-like idle state: shifting disabled
    @(negedge clk);
    checks++;
    if (bad_enc_o !== 1'b0 || value_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle got bad=%0b c=%0b v=%h exp 0 0 0", bad_enc_o, carry_o, value_o);
    end

    // Directed cases with values worked by hand
    apply_check("R7", 32'hDEADBEEF, 2'd2, 0, 0, 6'd16, 0, 0, 1);
    direct("R7 asr16", value_o, 32'hFFFFDEAD);
    apply_check("R10", 32'hDEADBEEF, 2'd0, 1, 0, 6'd0, 0, 0, 1);
    direct("R10 rrx c0", value_o, 32'h6F56DF77);
    apply_check("R10", 32'hDEADBEEF, 2'd3, 1, 1, 6'd0, 0, 1, 1);
    direct("R10 rrx c1", value_o, 32'hEF56DF77);
    apply_check("R9", 32'hDEADBEEF, 2'd0, 0, 1, 6'd0, 32'hBADBAD01, 0, 1);
    direct("R9 low byte", value_o, 32'hBD5B7DDE);
    apply_check("R9", 32'h00000110, 2'd1, 0, 1, 6'd0, 32'h80000004, 1, 1);
    direct("R9 lsr4", value_o, 32'h00000011);
    apply_check("R8", 32'hDEADBEEF, 2'd3, 0, 0, 6'd16, 0, 0, 1);
    direct("R8 ror16", value_o, 32'hBEEFDEAD);
    apply_check("R6", 32'hDEADBEEF, 2'd1, 0, 0, 6'd32, 0, 0, 1);
    direct("R6 lsr32 carry", {31'd0, carry_o}, 32'd1);
    apply_check("R3", 32'hDEADBEEF, 2'd3, 0, 0, 6'd32, 0, 1, 1);
    direct("R3 ror32 bad", {31'd0, bad_enc_o}, 32'd1);

    // R1: disabled pass-through across kinds and amounts
    for (int k = 0; k < 4; k++)
      apply_check("R1", pats[k], 2'(k), 1'(k & 1), 1'(k >> 1), 6'(k * 17), 32'hFFFFFF05, 1'(k & 1), 0);

    // R2 R3 R4 R5 R6 R7 R8: every kind with every immediate amount
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 64; a++)
          apply_check(k == 0 ? "R2" : (k == 3 ? "R3" : "R4"), pats[p], 2'(k), 0, 0, 6'(a), 32'hFFFFFFFF, 1'(a & 1), 1);

    // R9 R6 R7 R8: every low-byte register amount with junk upper bits
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          apply_check("R9", pats[p], 2'(k), 0, 1, 6'(a), {24'hA5C3E1 ^ 24'(a * 7), 8'(a)}, 1'(p & 1), 1);

    // R10: rotate-through-carry ignores kind, amount and source select
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 2; c++)
        apply_check("R10", pats[p], 2'(p % 4), 1, 1'(c), 6'(p * 11), 32'h000000FF, 1'(c), 1);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got=timeout exp=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule